// File: doc/BRIEF.md
# Global-History Correlating Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a table of small saturating up/down counters and a shift register that holds the outcomes of the most recently resolved branches. A lookup forms an index from a few word-address bits of the branch PC and the current history. It returns the top bit of the selected counter one cycle later. Branches that share the same address bits therefore get a separate counter for every possible recent-outcome pattern.

When a branch resolves, the update port presents its PC and its real outcome. The block recomputes the index from that PC and the history as it stands in that cycle. It moves only that counter one step toward the outcome, then shifts the outcome into the history. A parameter selects the index function. By default the history is placed above the address bits. In the alternative mode the two are XOR-folded into a narrower index.

Top module: `gcorr_predictor`

## Requirements
- R1: After reset every counter holds the weakly-not-taken value 2^(CTR_BITS-1)-1 (binary 01 for 2-bit counters), the history is all zeros, `pred_ready` and `pred_taken` are 0, and every lookup predicts not taken.
- R2: `pred_ready` is 1 in exactly the cycle after a cycle with `pred_valid` high, and `pred_taken` carries the result in that cycle.
- R3: A lookup answers taken (1) when the selected counter is at least 2^(CTR_BITS-1), and not taken (0) otherwise.
- R4: An update with outcome taken increments the selected counter, saturating at 2^CTR_BITS-1; an update with outcome not taken decrements it, saturating at 0.
- R5: With 2-bit counters, a counter that has saturated at taken keeps predicting taken after one not-taken update, and flips only after a second one.
- R6: Each update shifts its outcome into the history at bit 0, and older outcomes move toward the MSB (history 01 = not taken, then taken); cycles without an update leave the history unchanged.
- R7: In concatenation mode (USE_XOR=0) the index is {history, pc[ADDR_BITS+1:2]}, with the history in the upper bits.
- R8: In XOR mode (USE_XOR=1) the index is pc[ADDR_BITS+1:2] XOR history, both zero-extended to the wider of the two widths.
- R9: An update changes only the one counter it selects; all other counters keep their values.
- R10: A lookup and an update in the same cycle both use the history from before that cycle's shift, and a lookup that hits the counter being updated returns the value from before the update.
- R11: PC bits [1:0] and all bits above ADDR_BITS+1 have no effect on the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_valid | input | 1 | Lookup request |
| pred_pc | input | PC_W | PC of the branch being looked up |
| upd_valid | input | 1 | Resolved-branch update request |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| pred_ready | output | 1 | Registered lookup-result valid |
| pred_taken | output | 1 | Registered prediction, 1 = taken |

## Verification
The bench drives two instances from one stimulus stream, one per indexing mode, and compares both against an arithmetic model of counters and history. A sweep of every address slot under each of the four history values separates concatenated from XOR-folded indexing, and shows whether the history bit order is right. A directed taken/not-taken pattern on one slot checks the two-miss hysteresis. Same-cycle lookup and update on one slot, together with PCs whose ignored bits are set, check read-before-write and the masking of the PC. A long pseudo-random mix of lookups and updates then tests saturation and checks that neighbouring counters are left alone.

// File: rtl/bp_pkg.sv
package bp_pkg;

  // Width of the counter-table index for a given indexing mode.
  function automatic int idx_width(input int addr_bits, input int hist_bits, input int use_xor);
    if (use_xor != 0) return (addr_bits > hist_bits) ? addr_bits : hist_bits;
    return addr_bits + hist_bits;
  endfunction

endpackage

// File: rtl/bp_idx_hash.sv
module bp_idx_hash #(
  parameter int PC_W      = 32,
  parameter int ADDR_BITS = 4,
  parameter int HIST_BITS = 2,
  parameter int USE_XOR   = 0,
  parameter int IDX_W     = 6
) (
  input  logic [PC_W-1:0]      pc,
  input  logic [HIST_BITS-1:0] hist,
  output logic [IDX_W-1:0]     idx
);
  logic [ADDR_BITS-1:0] pc_slot;
  logic                 unused_pc_bits;

  assign pc_slot        = pc[ADDR_BITS+1:2];
  assign unused_pc_bits = ^{pc[PC_W-1:ADDR_BITS+2], pc[1:0]};

  generate
    if (USE_XOR != 0) begin : g_fold
      assign idx = IDX_W'(pc_slot) ^ IDX_W'(hist);
    end else begin : g_concat
      assign idx = {hist, pc_slot};
    end
  endgenerate
endmodule

// File: rtl/bp_hist_reg.sv
module bp_hist_reg #(
  parameter int HIST_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 shift_en,
  input  logic                 outcome,
  output logic [HIST_BITS-1:0] hist_q
);
  logic [HIST_BITS-1:0] hist_d;

  generate
    if (HIST_BITS == 1) begin : g_single
      assign hist_d = outcome;
    end else begin : g_multi
      assign hist_d = {hist_q[HIST_BITS-2:0], outcome};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)           hist_q <= '0;
    else if (shift_en) hist_q <= hist_d;
  end

  a_r6_newest_lsb: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (hist_q[0] == $past(outcome)));
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(hist_q));
endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table #(
  parameter int IDX_W  = 6,
  parameter int CTR_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_ready,
  output logic             rd_taken,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_dir
);
  localparam int              ENTRIES = 1 << IDX_W;
  localparam logic [CTR_W-1:0] CTR_MAX = '1;
  localparam logic [CTR_W-1:0] CTR_MIN = '0;
  localparam logic [CTR_W-1:0] CTR_RST = CTR_W'((1 << (CTR_W-1)) - 1);

  logic [CTR_W-1:0] ctr_q [ENTRIES];
  logic [CTR_W-1:0] cur_val;
  logic [CTR_W-1:0] nxt_val;

  assign cur_val = ctr_q[wr_idx];

  always_comb begin
    nxt_val = cur_val;
    if (wr_dir && cur_val != CTR_MAX)       nxt_val = cur_val + 1'b1;
    else if (!wr_dir && cur_val != CTR_MIN) nxt_val = cur_val - 1'b1;
  end

  // Counter storage: one write port; the read below samples pre-write data.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= CTR_RST;
    end else if (wr_en) begin
      ctr_q[wr_idx] <= nxt_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ready <= 1'b0;
      rd_taken <= 1'b0;
    end else begin
      rd_ready <= rd_en;
      if (rd_en) rd_taken <= ctr_q[rd_idx][CTR_W-1];
    end
  end

  a_r4_inc: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_dir && cur_val != CTR_MAX) |=> (ctr_q[$past(wr_idx)] == $past(cur_val) + 1'b1));
  a_r4_dec: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_dir && cur_val != CTR_MIN) |=> (ctr_q[$past(wr_idx)] == $past(cur_val) - 1'b1));
  a_r4_sat_top: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_dir && cur_val == CTR_MAX) |=> (ctr_q[$past(wr_idx)] == CTR_MAX));
  a_r4_sat_bot: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_dir && cur_val == CTR_MIN) |=> (ctr_q[$past(wr_idx)] == CTR_MIN));
  a_r2_ready: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_ready);
  a_r2_idle: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_ready);
endmodule

// File: rtl/gcorr_predictor.sv
module gcorr_predictor #(
  parameter int PC_W      = 32,
  parameter int ADDR_BITS = 4,
  parameter int HIST_BITS = 2,
  parameter int CTR_BITS  = 2,
  parameter int USE_XOR   = 0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pred_valid,
  input  logic [PC_W-1:0] pred_pc,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  output logic            pred_ready,
  output logic            pred_taken
);
  localparam int IDX_W = bp_pkg::idx_width(ADDR_BITS, HIST_BITS, USE_XOR);

  logic [HIST_BITS-1:0] hist_q;
  logic [IDX_W-1:0]     pred_idx;
  logic [IDX_W-1:0]     upd_idx;

  bp_hist_reg #(.HIST_BITS(HIST_BITS)) u_hist (
    .clk(clk), .rst(rst), .shift_en(upd_valid), .outcome(upd_taken), .hist_q(hist_q)
  );

  bp_idx_hash #(.PC_W(PC_W), .ADDR_BITS(ADDR_BITS), .HIST_BITS(HIST_BITS),
                .USE_XOR(USE_XOR), .IDX_W(IDX_W)) u_pred_hash (
    .pc(pred_pc), .hist(hist_q), .idx(pred_idx)
  );

  bp_idx_hash #(.PC_W(PC_W), .ADDR_BITS(ADDR_BITS), .HIST_BITS(HIST_BITS),
                .USE_XOR(USE_XOR), .IDX_W(IDX_W)) u_upd_hash (
    .pc(upd_pc), .hist(hist_q), .idx(upd_idx)
  );

  bp_ctr_table #(.IDX_W(IDX_W), .CTR_W(CTR_BITS)) u_table (
    .clk(clk), .rst(rst),
    .rd_en(pred_valid), .rd_idx(pred_idx), .rd_ready(pred_ready), .rd_taken(pred_taken),
    .wr_en(upd_valid), .wr_idx(upd_idx), .wr_dir(upd_taken)
  );

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (!pred_ready && !pred_taken));
endmodule

// File: tb/gcorr_predictor_tb.sv
`timescale 1ns/1ps
module gcorr_predictor_tb;
  localparam int A = 4;
  localparam int H = 2;
  localparam int AMASK = (1 << A) - 1;
  localparam int HMASK = (1 << H) - 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pv = 1'b0, uv = 1'b0, ut = 1'b0;
  logic [31:0] ppc = '0, upc = '0;
  logic        rdy_c, tkn_c, rdy_x, tkn_x;

  int nchk = 0;
  int nerr = 0;
  int mc [64];
  int mx [16];
  int mh;
  logic [15:0] lf = 16'hACE1;

  always #5 clk = ~clk;

  gcorr_predictor #(.ADDR_BITS(A), .HIST_BITS(H), .CTR_BITS(2), .USE_XOR(0)) u_dut (
    .clk(clk), .rst(rst), .pred_valid(pv), .pred_pc(ppc), .upd_valid(uv), .upd_pc(upc),
    .upd_taken(ut), .pred_ready(rdy_c), .pred_taken(tkn_c));

  gcorr_predictor #(.ADDR_BITS(A), .HIST_BITS(H), .CTR_BITS(2), .USE_XOR(1)) u_dut_x (
    .clk(clk), .rst(rst), .pred_valid(pv), .pred_pc(ppc), .upd_valid(uv), .upd_pc(upc),
    .upd_taken(ut), .pred_ready(rdy_x), .pred_taken(tkn_x));

  function automatic int ic(input logic [31:0] pc, input int h);
    return (h << A) | ((int'(pc) >> 2) & AMASK);
  endfunction
  function automatic int ix(input logic [31:0] pc, input int h);
    return ((int'(pc) >> 2) & AMASK) ^ h;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 64; i++) mc[i] = 1;
    for (int i = 0; i < 16; i++) mx[i] = 1;
    mh = 0;
  endtask

  // One cycle: drive, predict from pre-update model, update model, check after edge.
  task automatic step(input bit p, input logic [31:0] pp, input bit u,
                      input logic [31:0] up, input bit t, input string tag);
    int ec, ex, k;
    @(negedge clk);
    pv = p; ppc = pp; uv = u; upc = up; ut = t;
    ec = (mc[ic(pp, mh)] >= 2) ? 1 : 0;
    ex = (mx[ix(pp, mh)] >= 2) ? 1 : 0;
    if (u) begin
      k = ic(up, mh);
      mc[k] = t ? ((mc[k] < 3) ? mc[k] + 1 : 3) : ((mc[k] > 0) ? mc[k] - 1 : 0);
      k = ix(up, mh);
      mx[k] = t ? ((mx[k] < 3) ? mx[k] + 1 : 3) : ((mx[k] > 0) ? mx[k] - 1 : 0);
      mh = ((mh << 1) | int'(t)) & HMASK;
    end
    @(posedge clk);
    #1;
    chk(rdy_c == p && rdy_x == p, {"R2 ready ", tag}, int'(rdy_c), int'(p));
    if (p) begin
      chk(int'(tkn_c) == ec, {"R7 concat ", tag}, int'(tkn_c), ec);
      chk(int'(tkn_x) == ex, {"R8 xor ", tag}, int'(tkn_x), ex);
    end
  endtask

  task automatic sweep(input string tag);
    for (int s = 0; s < 16; s++) step(1'b1, 32'(s << 2), 1'b0, '0, 1'b0, tag);
  endtask

  initial begin
    #2000000;
    nerr++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(!rdy_c && !rdy_x && !tkn_c && !tkn_x, "R1 outputs after reset", int'(rdy_c), 0);
    sweep("R1 reset weak not taken");
    step(1'b0, '0, 1'b0, '0, 1'b0, "R2 idle");

    // R6 R7 R8: every history value, every slot
    for (int h = 0; h < 4; h++) begin
      step(1'b0, '0, 1'b1, 32'h3C, h[1], "R6 load hist");
      step(1'b0, '0, 1'b1, 32'h3C, h[0], "R6 load hist");
      sweep("R6 R3 history sweep");
    end

    // R5: two consecutive misses needed to flip a saturated counter
    repeat (6) step(1'b0, '0, 1'b1, 32'h20, 1'b1, "R4 train");
    step(1'b1, 32'h20, 1'b0, '0, 1'b0, "R5 saturated taken");
    chk(tkn_c == 1'b1, "R5 saturated predicts taken", int'(tkn_c), 1);
    step(1'b0, '0, 1'b1, 32'h20, 1'b0, "R5 miss1");
    step(1'b0, '0, 1'b1, 32'h20, 1'b1, "R5 refill");
    step(1'b0, '0, 1'b1, 32'h20, 1'b1, "R5 refill");
    step(1'b1, 32'h20, 1'b0, '0, 1'b0, "R5 after one miss");
    chk(tkn_c == 1'b1, "R5 one miss keeps taken", int'(tkn_c), 1);
    step(1'b0, '0, 1'b1, 32'h20, 1'b0, "R5 miss2");
    step(1'b0, '0, 1'b1, 32'h20, 1'b1, "R5 refill");
    step(1'b0, '0, 1'b1, 32'h20, 1'b1, "R5 refill");
    step(1'b1, 32'h20, 1'b0, '0, 1'b0, "R5 after two misses");
    chk(tkn_c == 1'b0, "R5 two misses flip", int'(tkn_c), 0);

    // R10: same-cycle lookup and update on the same slot
    for (int r = 0; r < 6; r++)
      step(1'b1, 32'h14, 1'b1, 32'h14, r[0], "R10 same cycle");

    // R11: ignored PC bits
    for (int s = 0; s < 16; s++)
      step(1'b1, 32'hFFFF_FFC3 ^ 32'hFFFF_FFC0 | 32'(s << 2) | 32'hABC0_0000 | 32'(s & 3),
           1'b0, '0, 1'b0, "R11 masked pc");

    // R9: neighbours untouched after single-slot updates
    repeat (3) step(1'b0, '0, 1'b1, 32'h08, 1'b0, "R9 hammer");
    sweep("R9 neighbours");

    // mixed traffic: R3 R4 R6 R9
    for (int n = 0; n < 1500; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[0], {lf[15:12], 20'h0, 2'b0, lf[4:1], lf[7:6]}, lf[8],
           {8'h0, 18'h0, lf[12:9], lf[3:2]}, lf[5] | lf[11], "R3 R4 R9 mixed");
    end
    sweep("R9 final sweep");

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule